// File: doc/BRIEF.md
# T1 Transmit Channel Payload Conditioner

This block sits in the transmit path of a T1/J1 line and handles one 8-bit channel octet per channel time slot. It applies trunk conditioning first. When conditioning is active, the channel payload is replaced by a programmed idle octet. In signaling frames, the least significant bit of that octet carries the programmed robbed-bit signaling value instead.

After conditioning, the block runs a zero code suppression check on the octet. If the octet is all zeros, one bit is forced to one so that the line keeps enough ones density. A 2-bit code selects the rule. The effective code is the bitwise OR of a global selector and a per-channel selector. The conditioned octet is registered, so it appears one clock after its inputs.

Channel bits are numbered 1 (MSB, sent first) to 8 (LSB). Bit 8 is `outOctet[0]` and bit 7 is `outOctet[1]`. Frame alignment, F-bit insertion and CRC generation are handled elsewhere.

Top module: `tx_chan_cond`

## Requirements
- R1: When `trunkCondEn` and `perChanCtlEn` are both 1, the output payload is `idleCode` instead of `chanOctet`.
- R2: When `perChanCtlEn` is 0, `trunkCondEn` is ignored and `chanOctet` passes unchanged (apart from suppression).
- R3: Under conditioning with `sigFrame`=1, output bit 8 (`[0]`) is the signaling bit chosen by `frameNum`: 6 selects A=`sigBits[3]`, 12 selects B=`sigBits[2]`, 18 selects C=`sigBits[1]`, and 24 (or any other value) selects D=`sigBits[0]`.
- R4: The effective suppression code is `globalZcs | chanZcs`, with 00 = none, 01 = GTE, 10 = reserved, 11 = Bell.
- R5: Under GTE, an all-zero octet leaves as 8'h01 (bit 8 forced) when `sigFrame`=0, and as 8'h02 (bit 7 forced) when `sigFrame`=1.
- R6: Under Bell, an all-zero octet leaves as 8'h02 (bit 7 forced) in every frame.
- R7: Under the codes 00 and 10, an all-zero octet leaves as 8'h00.
- R8: A nonzero octet is never altered by suppression.
- R9: The zero test applies to the octet after idle replacement and signaling insertion.
- R10: `outOctet` is 8'h00 during reset and reflects the inputs of the previous clock edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one octet per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| chanOctet | input | 8 | Incoming channel payload |
| frameNum | input | 5 | Frame number in the multiframe (1..24) |
| sigFrame | input | 1 | Current frame carries robbed-bit signaling |
| trunkCondEn | input | 1 | Master trunk conditioning request |
| perChanCtlEn | input | 1 | Per-channel control enable gating conditioning |
| globalZcs | input | 2 | Global suppression code |
| chanZcs | input | 2 | Per-channel suppression code |
| idleCode | input | 8 | Idle octet used under conditioning |
| sigBits | input | 4 | Signaling values {A,B,C,D} |
| outOctet | output | 8 | Conditioned octet, registered |

## Verification
A wrong strobe from the control side shows up at the output on the clock edge right after the stimulus, because there is only one register stage. If the force signals are swapped, an all-zero octet leaves as 01 where 02 was expected, or the other way round. If the signaling letter is decoded wrongly, the LSB flips only in particular frames, so every signaling frame number is driven with a distinct pattern. If zero detection runs on the raw input instead of the conditioned octet, the error appears only when the idle code is zero, so that case is driven separately.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int OCTET_W = 8;
  localparam int SIG_W   = 4;

  typedef enum logic [1:0] {
    ZCS_NONE = 2'b00,
    ZCS_GTE  = 2'b01,
    ZCS_RSVD = 2'b10,
    ZCS_BELL = 2'b11
  } zcsMode_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic replace;    // substitute idle code
    logic insertSig;  // overwrite LSB with signaling bit
    logic sigBit;     // value for LSB
    logic forceLsb;   // set bit 8 if zero
    logic forceB7;    // set bit 7 if zero
  } condStrb_t;
endpackage

// File: rtl/cond_ctl.sv
module cond_ctl
  import cond_pkg::*;
#(
  parameter int FRAME_W    = 5,
  parameter int SIG_PERIOD = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               sigFrame,
  input  logic               trunkCondEn,
  input  logic               perChanCtlEn,
  input  logic [1:0]         globalZcs,
  input  logic [1:0]         chanZcs,
  input  logic [SIG_W-1:0]   sigBits,
  output condStrb_t          strb
);
  localparam logic [FRAME_W-1:0] FRM_A = FRAME_W'(SIG_PERIOD);
  localparam logic [FRAME_W-1:0] FRM_B = FRAME_W'(2*SIG_PERIOD);
  localparam logic [FRAME_W-1:0] FRM_C = FRAME_W'(3*SIG_PERIOD);

  zcsMode_e effMode;
  logic     condOn;
  logic     letterBit;

  always_comb begin
    effMode = zcsMode_e'(globalZcs | chanZcs);
    condOn  = trunkCondEn & perChanCtlEn;
    if (frameNum == FRM_A)      letterBit = sigBits[3];
    else if (frameNum == FRM_B) letterBit = sigBits[2];
    else if (frameNum == FRM_C) letterBit = sigBits[1];
    else                        letterBit = sigBits[0];
  end

  always_comb begin
    strb           = '0;
    strb.replace   = condOn;
    strb.insertSig = condOn & sigFrame;
    strb.sigBit    = letterBit;
    unique case (effMode)
      ZCS_GTE: begin
        strb.forceLsb = ~sigFrame;
        strb.forceB7  = sigFrame;
      end
      ZCS_BELL: strb.forceB7 = 1'b1;
      default: ;
    endcase
  end

  assert_pcce_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    !perChanCtlEn |-> !strb.replace && !strb.insertSig);
  assert_single_force_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.forceLsb, strb.forceB7}));
  assert_gte_sig_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.forceLsb) |-> !sigFrame);
  assert_quiet_codes_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((globalZcs | chanZcs) == 2'b10 || (globalZcs | chanZcs) == 2'b00)
      |-> !strb.forceLsb && !strb.forceB7);
endmodule

// File: rtl/cond_dp.sv
module cond_dp
  import cond_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [OCTET_W-1:0] chanOctet,
  input  logic [OCTET_W-1:0] idleCode,
  input  condStrb_t          strb,
  output logic [OCTET_W-1:0] outOctet
);
  logic [OCTET_W-1:0] condOctet;
  logic [OCTET_W-1:0] suppOctet;
  logic               isZero;
  logic               armed;

  always_comb begin
    condOctet = strb.replace ? idleCode : chanOctet;
    if (strb.insertSig) condOctet[0] = strb.sigBit;
    isZero    = (condOctet == '0);
    suppOctet = condOctet;
    if (isZero && strb.forceLsb) suppOctet[0] = 1'b1;
    if (isZero && strb.forceB7)  suppOctet[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outOctet <= '0;
      armed    <= 1'b0;
    end else begin
      outOctet <= suppOctet;
      armed    <= 1'b1;
    end
  end

  assert_idle_upper_R1: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strb.replace) |-> outOctet[OCTET_W-1:2] == $past(idleCode[OCTET_W-1:2]));
  assert_sig_lsb_R3: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strb.insertSig) && $past(strb.sigBit) |-> outOctet[0]);
  assert_never_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(strb.forceLsb || strb.forceB7) |-> outOctet != '0);
  assert_nonzero_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    armed && !$past(strb.replace) && $past(chanOctet) != '0 |-> outOctet == $past(chanOctet));
endmodule

// File: rtl/tx_chan_cond.sv
module tx_chan_cond
  import cond_pkg::*;
#(
  parameter int FRAME_W    = 5,
  parameter int SIG_PERIOD = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OCTET_W-1:0] chanOctet,
  input  logic [FRAME_W-1:0] frameNum,
  input  logic               sigFrame,
  input  logic               trunkCondEn,
  input  logic               perChanCtlEn,
  input  logic [1:0]         globalZcs,
  input  logic [1:0]         chanZcs,
  input  logic [OCTET_W-1:0] idleCode,
  input  logic [SIG_W-1:0]   sigBits,
  output logic [OCTET_W-1:0] outOctet
);
  condStrb_t strb;

  cond_ctl #(.FRAME_W(FRAME_W), .SIG_PERIOD(SIG_PERIOD)) u_ctl (
    .clk(clk), .rstN(rstN), .frameNum(frameNum), .sigFrame(sigFrame),
    .trunkCondEn(trunkCondEn), .perChanCtlEn(perChanCtlEn),
    .globalZcs(globalZcs), .chanZcs(chanZcs), .sigBits(sigBits), .strb(strb)
  );

  cond_dp u_dp (
    .clk(clk), .rstN(rstN), .chanOctet(chanOctet), .idleCode(idleCode),
    .strb(strb), .outOctet(outOctet)
  );
endmodule

// File: tb/tx_chan_cond_test.sv
module tx_chan_cond_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] chanOctet = '0;
  logic [4:0] frameNum = 5'd1;
  logic       sigFrame = 1'b0;
  logic       trunkCondEn = 1'b0;
  logic       perChanCtlEn = 1'b0;
  logic [1:0] globalZcs = '0;
  logic [1:0] chanZcs = '0;
  logic [7:0] idleCode = '0;
  logic [3:0] sigBits = '0;
  logic [7:0] outOctet;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tx_chan_cond uut (
    .clk(clk), .rstN(rstN), .chanOctet(chanOctet), .frameNum(frameNum),
    .sigFrame(sigFrame), .trunkCondEn(trunkCondEn), .perChanCtlEn(perChanCtlEn),
    .globalZcs(globalZcs), .chanZcs(chanZcs), .idleCode(idleCode),
    .sigBits(sigBits), .outOctet(outOctet)
  );

  // {req, octet, frame, sig, mtrk, pcce, gz, cz, idle, sigBits, expected}
  localparam int NV = 20;
  localparam logic [43:0] VECS [NV] = '{
    {4'd8, 8'h5A, 5'd1,  1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 8'h7F, 4'b0000, 8'h5A}, // R8 pass
    {4'd1, 8'h5A, 5'd1,  1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 8'h7F, 4'b0000, 8'h7F}, // R1
    {4'd2, 8'h5A, 5'd1,  1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 8'h7F, 4'b0000, 8'h5A}, // R2
    {4'd3, 8'h5A, 5'd6,  1'b1, 1'b1, 1'b1, 2'b00, 2'b00, 8'h7E, 4'b1000, 8'h7F}, // R3 A
    {4'd3, 8'h5A, 5'd12, 1'b1, 1'b1, 1'b1, 2'b00, 2'b00, 8'h7E, 4'b0100, 8'h7F}, // R3 B
    {4'd3, 8'h5A, 5'd18, 1'b1, 1'b1, 1'b1, 2'b00, 2'b00, 8'h7E, 4'b0010, 8'h7F}, // R3 C
    {4'd3, 8'h5A, 5'd24, 1'b1, 1'b1, 1'b1, 2'b00, 2'b00, 8'h7E, 4'b0001, 8'h7F}, // R3 D
    {4'd3, 8'h5A, 5'd24, 1'b1, 1'b1, 1'b1, 2'b00, 2'b00, 8'h7F, 4'b1110, 8'h7E}, // R3 D=0
    {4'd5, 8'h00, 5'd1,  1'b0, 1'b0, 1'b0, 2'b01, 2'b00, 8'h00, 4'b0000, 8'h01}, // R5
    {4'd5, 8'h00, 5'd6,  1'b1, 1'b0, 1'b0, 2'b01, 2'b00, 8'h00, 4'b0000, 8'h02}, // R5 sig
    {4'd6, 8'h00, 5'd1,  1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 8'h00, 4'b0000, 8'h02}, // R6
    {4'd6, 8'h00, 5'd12, 1'b1, 1'b0, 1'b0, 2'b11, 2'b00, 8'h00, 4'b0000, 8'h02}, // R6 sig
    {4'd7, 8'h00, 5'd1,  1'b0, 1'b0, 1'b0, 2'b10, 2'b00, 8'h00, 4'b0000, 8'h00}, // R7 rsvd
    {4'd7, 8'h00, 5'd1,  1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 8'h00, 4'b0000, 8'h00}, // R7 none
    {4'd4, 8'h00, 5'd1,  1'b0, 1'b0, 1'b0, 2'b01, 2'b10, 8'h00, 4'b0000, 8'h02}, // R4 OR->Bell
    {4'd4, 8'h00, 5'd1,  1'b0, 1'b0, 1'b0, 2'b00, 2'b01, 8'h00, 4'b0000, 8'h01}, // R4 chan GTE
    {4'd8, 8'h80, 5'd1,  1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 8'h00, 4'b0000, 8'h80}, // R8 nonzero
    {4'd9, 8'h5A, 5'd1,  1'b0, 1'b1, 1'b1, 2'b01, 2'b00, 8'h00, 4'b0000, 8'h01}, // R9 idle zero
    {4'd9, 8'h5A, 5'd6,  1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 8'h00, 4'b0000, 8'h02}, // R9 sig zero
    {4'd9, 8'h00, 5'd6,  1'b1, 1'b1, 1'b1, 2'b01, 2'b00, 8'h00, 4'b1000, 8'h01}  // R9 sig A=1
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #2000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(10, outOctet, 8'h00);  // R10 reset value
    chanOctet = 8'hC3;
    @(negedge clk);
    check(10, outOctet, 8'h00);  // R10 held in reset
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      chanOctet    = VECS[i][39:32];
      frameNum     = VECS[i][31:27];
      sigFrame     = VECS[i][26];
      trunkCondEn  = VECS[i][25];
      perChanCtlEn = VECS[i][24];
      globalZcs    = VECS[i][23:22];
      chanZcs      = VECS[i][21:20];
      idleCode     = VECS[i][19:12];
      sigBits      = VECS[i][11:8];
      @(negedge clk);
      check(int'(VECS[i][43:40]), outOctet, VECS[i][7:0]);
    end

    // R10 latency: new input not visible before the next edge
    trunkCondEn = 1'b0; perChanCtlEn = 1'b0; globalZcs = 2'b00; chanZcs = 2'b00;
    sigFrame = 1'b0; frameNum = 5'd2; chanOctet = 8'h33;
    #5;
    check(10, outOctet, 8'h01);
    @(negedge clk);
    check(10, outOctet, 8'h33);
    // R2 gate with conditioning requested, sig frame
    trunkCondEn = 1'b1; sigFrame = 1'b1; frameNum = 5'd6; chanOctet = 8'h44;
    idleCode = 8'hFF; sigBits = 4'b0000;
    @(negedge clk);
    check(2, outOctet, 8'h44);
    // R10 reset mid-run
    rstN = 1'b0;
    #1;
    check(10, outOctet, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(2, outOctet, 8'h44);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule